// File: doc/BRIEF.md
# Timer Interrupt Vector Encoder

This block merges three timer interrupt sources into one prioritized vector value: the pending flags of compare channels 1 and 2 and the counter wrap flag. Each source has a flag and an enable input. A source takes part only when both are high. The vector shows a fixed even code for the highest-priority enabled pending source. Priority runs channel 1, then channel 2, then counter wrap.

When software reads the vector, it pulses the read strobe for one cycle. The block then acknowledges the reported source and nothing else. It does this through a one-cycle clear pulse on that source's clear line. The flag sources themselves live outside the block and own their set and clear logic.

A small state machine does the acknowledgment. It has two states. `ST_IDLE` is the rest state. `ST_ACK` is the cycle in which the clear pulse goes out.

The transitions are:
- `IDLE->ACK`: a read while the vector is nonzero.
- `IDLE->IDLE`: no read, or a read while the vector is zero.
- `ACK->ACK`: another read while the masked vector is nonzero.
- `ACK->IDLE`: otherwise.

While in `ST_ACK`, the acknowledged source is masked out of the encoding. This lets the vector already show the next pending source while the flag is being cleared.

Top module: `tmr_irq_vector`

## Requirements
- R1: With no source both flagged and enabled, `vec_o` is 0x0000, including right after reset.
- R2: Channel 1 flagged and enabled gives `vec_o` = 0x0002, regardless of the other sources.
- R3: Channel 2 flagged and enabled, with channel 1 not reporting, gives `vec_o` = 0x0004.
- R4: Counter wrap flagged and enabled, with neither channel reporting, gives `vec_o` = 0x000A.
- R5: `vec_o` only ever takes the values 0x0000, 0x0002, 0x0004 or 0x000A. It is never odd and never 0x0006, 0x0008 or above 0x000A.
- R6: A flag whose enable is low has no effect on `vec_o` and is never cleared.
- R7: A read strobe sampled at a clock edge while `vec_o` is nonzero gives, in the following cycle, a single-cycle pulse on the clear line of the reported source only. The clear lines are `clr_ch1_o`, `clr_ch2_o` and `clr_ovf_o`.
- R8: During the clear pulse cycle, `vec_o` ignores the source being cleared and shows the next enabled pending source, or 0x0000 if there is none.
- R9: A read strobe sampled while `vec_o` is 0x0000 produces no clear pulse.
- R10: A flag that rises in the same cycle as a read, or during the clear pulse, is not cleared unless it is the reported source. It is reported once the current acknowledgment ends.
- R11: A synchronous active-high `rst` returns the machine to `ST_IDLE` with all clear lines low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ch1_flag_i | input | 1 | Channel 1 pending flag |
| ch1_en_i | input | 1 | Channel 1 interrupt enable |
| ch2_flag_i | input | 1 | Channel 2 pending flag |
| ch2_en_i | input | 1 | Channel 2 interrupt enable |
| ovf_flag_i | input | 1 | Counter wrap pending flag |
| ovf_en_i | input | 1 | Counter wrap interrupt enable |
| rd_i | input | 1 | Vector read strobe, one cycle per read |
| vec_o | output | VEC_W (16) | Prioritized vector code |
| clr_ch1_o | output | 1 | Clear pulse to channel 1 flag |
| clr_ch2_o | output | 1 | Clear pulse to channel 2 flag |
| clr_ovf_o | output | 1 | Clear pulse to counter wrap flag |

## Verification
A read acknowledgment and the arrival of a new flag can coincide. The bench provokes this in two ways: it raises channel 1 in the same cycle as a read that reports channel 2, and it raises channel 1 during the clear pulse of channel 2. In both cases it judges the clear lines and the vector. Only the reported source may see a clear pulse, and the newcomer must appear in the vector the moment the mask allows it. Back-to-back reads that overlap a pending clear pulse are also driven, to check that each read acknowledges a different source.

// File: rtl/tiv_pkg.sv
package tiv_pkg;
    localparam int NSRC = 3;

    // index order is the priority order: lowest index wins
    typedef enum logic [1:0] {
        SEL_CH1  = 2'd0,
        SEL_CH2  = 2'd1,
        SEL_OVF  = 2'd2,
        SEL_NONE = 2'd3
    } sel_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } ack_state_t;

    localparam logic [3:0] CODE_NONE = 4'h0;
    localparam logic [3:0] CODE_CH1  = 4'h2;
    localparam logic [3:0] CODE_CH2  = 4'h4;
    localparam logic [3:0] CODE_OVF  = 4'hA;
endpackage

// File: rtl/tiv_prio_enc.sv
module tiv_prio_enc
    import tiv_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] mask_i,
    output sel_t         sel_o
);
    logic [N-1:0] live;

    assign live = req_i & ~mask_i;

    // scan from lowest priority upward so the highest-priority hit is last
    always_comb begin
        sel_o = SEL_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (live[i]) begin
                sel_o = sel_t'(2'(i));
            end
        end
    end
endmodule

// File: rtl/tiv_code_map.sv
module tiv_code_map
    import tiv_pkg::*;
#(
    parameter int VEC_W = 16
) (
    input  sel_t             sel_i,
    output logic [VEC_W-1:0] vec_o
);
    always_comb begin
        unique case (sel_i)
            SEL_CH1:  vec_o = VEC_W'(CODE_CH1);
            SEL_CH2:  vec_o = VEC_W'(CODE_CH2);
            SEL_OVF:  vec_o = VEC_W'(CODE_OVF);
            SEL_NONE: vec_o = VEC_W'(CODE_NONE);
        endcase
    end
endmodule

// File: rtl/tiv_ack_fsm.sv
module tiv_ack_fsm
    import tiv_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rd_i,
    input  sel_t         sel_i,
    output logic [N-1:0] clr_o
);
    ack_state_t state_q, state_d;
    sel_t       ack_q, ack_d;
    logic       take;

    assign take = rd_i && (sel_i != SEL_NONE);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ack_q   <= SEL_NONE;
        end else begin
            state_q <= state_d;
            ack_q   <= ack_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        ack_d   = ack_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take) begin
                    state_d = ST_ACK;
                    ack_d   = sel_i;
                end
            end
            ST_ACK: begin
                if (take) begin
                    state_d = ST_ACK;
                    ack_d   = sel_i;
                end else begin
                    state_d = ST_IDLE;
                    ack_d   = SEL_NONE;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        clr_o = '0;
        unique case (state_q)
            ST_IDLE: clr_o = '0;
            ST_ACK: begin
                for (int i = 0; i < N; i++) begin
                    clr_o[i] = (ack_q == sel_t'(2'(i)));
                end
            end
        endcase
    end
endmodule

// File: rtl/tmr_irq_vector.sv
module tmr_irq_vector
    import tiv_pkg::*;
#(
    parameter int VEC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ch1_flag_i,
    input  logic             ch1_en_i,
    input  logic             ch2_flag_i,
    input  logic             ch2_en_i,
    input  logic             ovf_flag_i,
    input  logic             ovf_en_i,
    input  logic             rd_i,
    output logic [VEC_W-1:0] vec_o,
    output logic             clr_ch1_o,
    output logic             clr_ch2_o,
    output logic             clr_ovf_o
);
    logic [NSRC-1:0] req;
    logic [NSRC-1:0] clr;
    sel_t            sel;

    assign req = {ovf_flag_i & ovf_en_i,
                  ch2_flag_i & ch2_en_i,
                  ch1_flag_i & ch1_en_i};

    tiv_prio_enc #(.N(NSRC)) u_enc (
        .req_i  (req),
        .mask_i (clr),
        .sel_o  (sel)
    );

    tiv_code_map #(.VEC_W(VEC_W)) u_map (
        .sel_i (sel),
        .vec_o (vec_o)
    );

    tiv_ack_fsm #(.N(NSRC)) u_fsm (
        .clk   (clk),
        .rst   (rst),
        .rd_i  (rd_i),
        .sel_i (sel),
        .clr_o (clr)
    );

    assign clr_ch1_o = clr[0];
    assign clr_ch2_o = clr[1];
    assign clr_ovf_o = clr[2];
endmodule

// File: rtl/tiv_checker.sv
module tiv_checker #(
    parameter int VEC_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             ch1_flag_i,
    input logic             ch1_en_i,
    input logic             ch2_flag_i,
    input logic             ch2_en_i,
    input logic             ovf_flag_i,
    input logic             ovf_en_i,
    input logic             rd_i,
    input logic [VEC_W-1:0] vec_o,
    input logic             clr_ch1_o,
    input logic             clr_ch2_o,
    input logic             clr_ovf_o
);
    logic any_clr;
    assign any_clr = clr_ch1_o | clr_ch2_o | clr_ovf_o;

    // R1
    quiet_vec_chk: assert property (@(posedge clk) disable iff (rst)
        !(ch1_flag_i && ch1_en_i) && !(ch2_flag_i && ch2_en_i) && !(ovf_flag_i && ovf_en_i)
        |-> vec_o == '0);

    // R2
    ch1_code_chk: assert property (@(posedge clk) disable iff (rst)
        (ch1_flag_i && ch1_en_i && !clr_ch1_o) |-> vec_o == VEC_W'(2));

    // R5
    legal_code_chk: assert property (@(posedge clk) disable iff (rst)
        vec_o == '0 || vec_o == VEC_W'(2) || vec_o == VEC_W'(4) || vec_o == VEC_W'(10));

    // R7
    one_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({clr_ch1_o, clr_ch2_o, clr_ovf_o}));

    // R7
    ch1_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_i && vec_o == VEC_W'(2)) |=> clr_ch1_o);

    // R7
    clear_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
        any_clr |-> $past(rd_i));

    // R8
    masked_vec_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_ch1_o |-> vec_o != VEC_W'(2)) and (clr_ch2_o |-> vec_o != VEC_W'(4))
        and (clr_ovf_o |-> vec_o != VEC_W'(10)));

    // R9
    idle_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_i && vec_o == '0) |=> !any_clr);
endmodule

bind tmr_irq_vector tiv_checker #(.VEC_W(VEC_W)) u_tiv_checker (
    .clk        (clk),
    .rst        (rst),
    .ch1_flag_i (ch1_flag_i),
    .ch1_en_i   (ch1_en_i),
    .ch2_flag_i (ch2_flag_i),
    .ch2_en_i   (ch2_en_i),
    .ovf_flag_i (ovf_flag_i),
    .ovf_en_i   (ovf_en_i),
    .rd_i       (rd_i),
    .vec_o      (vec_o),
    .clr_ch1_o  (clr_ch1_o),
    .clr_ch2_o  (clr_ch2_o),
    .clr_ovf_o  (clr_ovf_o)
);

// File: tb/test_tmr_irq_vector.sv
`timescale 1ns/1ps
module test_tmr_irq_vector;
    localparam int VEC_W = 16;
    localparam int NV    = 11;

    // entry: {f1,e1,f2,e2,fo,eo, expected code[3:0]}
    localparam logic [9:0] VECS [NV] = '{
        {6'b000000, 4'h0},
        {6'b110000, 4'h2},
        {6'b100000, 4'h0},
        {6'b001100, 4'h4},
        {6'b000011, 4'hA},
        {6'b111111, 4'h2},
        {6'b101111, 4'h4},
        {6'b101011, 4'hA},
        {6'b011011, 4'hA},
        {6'b010101, 4'h0},
        {6'b001111, 4'h4}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic f1 = 0, e1 = 0, f2 = 0, e2 = 0, fo = 0, eo = 0, rd = 0;
    logic [VEC_W-1:0] vec;
    logic c1, c2, co;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tmr_irq_vector #(.VEC_W(VEC_W)) i_tmr_irq_vector (
        .clk(clk), .rst(rst),
        .ch1_flag_i(f1), .ch1_en_i(e1),
        .ch2_flag_i(f2), .ch2_en_i(e2),
        .ovf_flag_i(fo), .ovf_en_i(eo),
        .rd_i(rd), .vec_o(vec),
        .clr_ch1_o(c1), .clr_ch2_o(c2), .clr_ovf_o(co)
    );

    task automatic check(string tag, logic [VEC_W-1:0] act, logic [VEC_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // vector and the three clear lines as {c1,c2,co}
    task automatic expect_state(string tag, logic [3:0] code, logic [2:0] clrs);
        check({tag, " vec"}, vec, VEC_W'(code));
        check({tag, " clr"}, VEC_W'({c1, c2, co}), VEC_W'(clrs));
    endtask

    // move to the middle of the next low phase, after the edge settled
    task automatic next_cycle();
        @(negedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R11 R1: reset state
        next_cycle();
        next_cycle();
        expect_state("R11 R1 reset", 4'h0, 3'b000);
        rd = 1;
        next_cycle();
        expect_state("R11 read under reset", 4'h0, 3'b000);
        rd = 0;
        rst = 0;
        next_cycle();

        // R2 R3 R4 R5 R6: static table, no reads
        for (int k = 0; k < NV; k++) begin
            {f1, e1, f2, e2, fo, eo} = VECS[k][9:4];
            #2;
            check($sformatf("R2 R3 R4 R6 table %0d", k), vec, VEC_W'(VECS[k][3:0]));
            check($sformatf("R5 legal %0d", k), VEC_W'(vec == 0 || vec == 2 || vec == 4 || vec == 10), 1);
            check($sformatf("R6 no clear %0d", k), VEC_W'({c1, c2, co}), 0);
            next_cycle();
        end

        // R7 R8: read reports ch1, pulse on ch1 only, vector moves on
        {f1, e1, f2, e2, fo, eo} = 6'b111111;
        #2;
        expect_state("R2 all pending", 4'h2, 3'b000);
        rd = 1;
        next_cycle();
        rd = 0;
        #1;
        expect_state("R7 R8 ch1 ack", 4'h4, 3'b100);
        f1 = 0;
        next_cycle();
        expect_state("R7 pulse single cycle", 4'h4, 3'b000);

        // R10: ch1 rises during ch2's clear pulse
        rd = 1;
        next_cycle();
        rd = 0;
        f1 = 1;
        #1;
        expect_state("R10 ch1 during ch2 ack", 4'h2, 3'b010);
        f2 = 0;
        next_cycle();
        expect_state("R10 ch1 kept", 4'h2, 3'b000);

        // R10: ch1 rises together with a read; the read then reports ch1 and ovf stays
        {f1, f2, fo} = 3'b011;
        #1;
        expect_state("R3 ch2 before read", 4'h4, 3'b000);
        f1 = 1;
        rd = 1;
        next_cycle();
        rd = 0;
        #1;
        expect_state("R10 same cycle read", 4'h4, 3'b100);
        f1 = 0;
        next_cycle();
        expect_state("R10 ch2 still pending", 4'h4, 3'b000);

        // R7 R8: back-to-back reads, each acknowledges a different source
        {f1, f2, fo} = 3'b101;
        #1;
        rd = 1;
        next_cycle();
        expect_state("R8 ovf visible in ch1 ack", 4'hA, 3'b100);
        f1 = 0;
        next_cycle();
        rd = 0;
        #1;
        expect_state("R7 second read clears ovf", 4'h0, 3'b001);
        fo = 0;
        next_cycle();
        expect_state("R1 all quiet", 4'h0, 3'b000);

        // R9: read with nothing pending
        f2 = 1;
        e2 = 0;
        rd = 1;
        next_cycle();
        rd = 0;
        #1;
        expect_state("R9 R6 idle read", 4'h0, 3'b000);
        next_cycle();
        e2 = 1;
        #1;
        expect_state("R6 disabled flag kept", 4'h4, 3'b000);

        // R11: reset during a pending ack drops the pulse
        rd = 1;
        next_cycle();
        rd = 0;
        rst = 1;
        next_cycle();
        expect_state("R11 reset mid ack", 4'h4, 3'b000);
        rst = 0;

        finish_run();
    end
endmodule